// File: doc/BRIEF.md
# Counting Memory-Mapped Interrupt Controller

This block gathers a parameterised set of level-sensitive interrupt lines, 64 by default, into one interrupt towards a parent. Every line has its own enable bit. The block keeps a running tally of the lines that are both high and enabled, and it holds its parent interrupt high whenever that tally is nonzero. The tally is not recounted from a mask. Each clock adds the lines that rose and subtracts the lines that fell, counting only enabled lines, and then applies any enable or disable command.

Software reaches the block through a small word-addressed register bus that spans a 4 KiB window. It can read an identification word, the pending tally, and the number of the lowest active line. It can turn a single line on or off by writing that line's number as data, or it can turn every line off at once. An access to an unassigned word is dropped and raises a one-cycle error pulse.

Top module: `cnt_irq_ctrl`

## Requirements
- R1: `irq_out` is high exactly when the pending count is nonzero. It updates on the same clock edge that samples the input change or the command that moved the count.
- R2: Registers are selected by word index `bus_addr[11:2]`. The two low address bits are ignored.
- R3: A read of word 0 returns the identification constant `ID_VALUE` (default 0x1C7A0040). All reads return their data on `bus_rdata` one cycle after `bus_rd`.
- R4: A read of word 1 returns the pending count, which is the number of lines whose sampled level and enable are both 1.
- R5: A read of word 2 returns the lowest line number whose level and enable are both 1. It returns 0xFFFFFFFF when no line is active.
- R6: A level change on an enabled line moves the count by one: up for a rising level, down for a falling level. A level change on a disabled line, or an unchanged level, leaves the count as it is.
- R7: A write to word 3 clears every enable bit and forces the count to zero.
- R8: A write to word 5 with data k enables line k if it is disabled, and adds one to the count if line k is high. Enabling a line that is already enabled has no effect.
- R9: A write to word 4 with data k disables line k if it is enabled, and removes one from the count if line k is high.
- R10: A write to word 4 or word 5 whose data is at least `NUM_SRC` is ignored and raises no error.
- R11: A read of any word other than 0 to 2, or a write to any word other than 3 to 5, returns zero (for a read) or changes nothing (for a write). It also pulses `bus_err` high for one cycle, one cycle after the access.
- R12: When a line's level changes in the same cycle as a command on that line, the level change is applied first and the command then sees the new level. The count therefore always equals the number of active lines after the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Level interrupt lines |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data (line number for enable and disable) |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an unassigned access |
| irq_out | output | 1 | Interrupt to parent |

## Verification
A level edge on a line and an enable or disable command naming that same line can land in one clock, and the two updates interact. The bench provokes this by raising line 63 in the same cycle that the enable write for line 63 is issued. In a later cycle it drops line 63 in the same cycle that the disable write for line 63 is issued. It judges each outcome by the parent interrupt and by reading the count back: the count must be one after the first case and zero after the second, and it must never end up doubled or negative.

// File: rtl/cic_pkg.sv
package cic_pkg;
  typedef enum logic [1:0] {
    CMD_NONE,
    CMD_DIS_ALL,
    CMD_DIS_ONE,
    CMD_EN_ONE
  } cmd_e;

  typedef enum logic [1:0] {
    RS_NONE,
    RS_ID,
    RS_CNT,
    RS_CUR
  } rsel_e;
endpackage

// File: rtl/ic_regdec.sv
module ic_regdec
  import cic_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  output cmd_e              cmd,
  output logic [IDX_W-1:0]  cmd_idx,
  output rsel_e             rsel,
  output logic              bad_acc
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam logic [WIDX_W-1:0] W_ID      = WIDX_W'(0);
  localparam logic [WIDX_W-1:0] W_CNT     = WIDX_W'(1);
  localparam logic [WIDX_W-1:0] W_CUR     = WIDX_W'(2);
  localparam logic [WIDX_W-1:0] W_DIS_ALL = WIDX_W'(3);
  localparam logic [WIDX_W-1:0] W_DIS_ONE = WIDX_W'(4);
  localparam logic [WIDX_W-1:0] W_EN_ONE  = WIDX_W'(5);

  logic [WIDX_W-1:0] widx;
  logic              idx_ok;
  logic              unused_lo;

  assign widx      = addr[ADDR_W-1:2];
  assign unused_lo = ^addr[1:0];
  assign idx_ok    = (wdata < DATA_W'(NUM_SRC));
  assign cmd_idx   = wdata[IDX_W-1:0];

  always_comb begin
    rsel    = RS_NONE;
    cmd     = CMD_NONE;
    bad_acc = 1'b0;
    if (rd) begin
      unique case (widx)
        W_ID:    rsel = RS_ID;
        W_CNT:   rsel = RS_CNT;
        W_CUR:   rsel = RS_CUR;
        default: bad_acc = 1'b1;
      endcase
    end
    if (wr) begin
      unique case (widx)
        W_DIS_ALL: cmd = CMD_DIS_ALL;
        W_DIS_ONE: cmd = idx_ok ? CMD_DIS_ONE : CMD_NONE;
        W_EN_ONE:  cmd = idx_ok ? CMD_EN_ONE : CMD_NONE;
        default:   bad_acc = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/ic_lowest.sv
module ic_lowest #(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6
) (
  input  logic [NUM_SRC-1:0] act,
  output logic               found,
  output logic [IDX_W-1:0]   idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ic_pend.sv
module ic_pend
  import cic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int IDX_W   = 6,
  parameter int CW      = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  cmd_e               cmd,
  input  logic [IDX_W-1:0]   cmd_idx,
  output logic [NUM_SRC-1:0] lvl_q,
  output logic [NUM_SRC-1:0] en_q,
  output logic [CW-1:0]      cnt_q,
  output logic               irq_q
);
  logic [NUM_SRC-1:0] rise, fall, en_next;
  logic [CW-1:0]      n_rise, n_fall, cnt_next;
  logic [CW:0]        up, dn, diff;
  logic               inc, dec;

  assign rise = irq_in & ~lvl_q & en_q;
  assign fall = ~irq_in & lvl_q & en_q;

  always_comb begin
    n_rise = '0;
    n_fall = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      n_rise = n_rise + CW'(rise[i]);
      n_fall = n_fall + CW'(fall[i]);
    end
  end

  // command is applied after the level update, so it sees the new level
  assign inc = (cmd == CMD_EN_ONE)  && !en_q[cmd_idx] && irq_in[cmd_idx];
  assign dec = (cmd == CMD_DIS_ONE) &&  en_q[cmd_idx] && irq_in[cmd_idx];

  assign up   = {1'b0, cnt_q} + {1'b0, n_rise} + (CW+1)'(inc);
  assign dn   = {1'b0, n_fall} + (CW+1)'(dec);
  assign diff = up - dn;

  always_comb begin
    en_next  = en_q;
    cnt_next = diff[CW-1:0];
    unique case (cmd)
      CMD_DIS_ALL: begin
        en_next  = '0;
        cnt_next = '0;
      end
      CMD_DIS_ONE: en_next[cmd_idx] = 1'b0;
      CMD_EN_ONE:  en_next[cmd_idx] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      en_q  <= '0;
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      lvl_q <= irq_in;
      en_q  <= en_next;
      cnt_q <= cnt_next;
      irq_q <= (cnt_next != '0);
    end
  end

  // R1
  irq_follows_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q == (cnt_q != '0));

  // R4
  cnt_tracks_state_chk: assert property (@(posedge clk) disable iff (rst)
    int'(cnt_q) == $countones(lvl_q & en_q));

  // R7
  dis_all_clears_chk: assert property (@(posedge clk) disable iff (rst)
    cmd == CMD_DIS_ALL |=> (cnt_q == '0 && en_q == '0));

  // R6
  quiet_holds_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd == CMD_NONE && ((irq_in ^ lvl_q) & en_q) == '0) |=> $stable(cnt_q));
endmodule

// File: rtl/cnt_irq_ctrl.sv
module cnt_irq_ctrl
  import cic_pkg::*;
#(
  parameter int          NUM_SRC  = 64,
  parameter int          ADDR_W   = 12,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h1C7A_0040
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_rd,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               bus_err,
  output logic               irq_out
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CW    = $clog2(NUM_SRC + 1);

  cmd_e               cmd;
  rsel_e              rsel;
  logic [IDX_W-1:0]   cmd_idx, low_idx;
  logic               bad_acc, low_found;
  logic [NUM_SRC-1:0] lvl_q, en_q;
  logic [CW-1:0]      cnt_q;

  ic_regdec #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .wdata(bus_wdata),
    .cmd(cmd), .cmd_idx(cmd_idx), .rsel(rsel), .bad_acc(bad_acc)
  );

  ic_pend #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .CW(CW)
  ) u_pend (
    .clk(clk), .rst(rst), .irq_in(irq_in), .cmd(cmd), .cmd_idx(cmd_idx),
    .lvl_q(lvl_q), .en_q(en_q), .cnt_q(cnt_q), .irq_q(irq_out)
  );

  ic_lowest #(
    .NUM_SRC(NUM_SRC), .IDX_W(IDX_W)
  ) u_low (
    .act(lvl_q & en_q), .found(low_found), .idx(low_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      bus_err <= bad_acc;
      unique case (rsel)
        RS_ID:   bus_rdata <= DATA_W'(ID_VALUE);
        RS_CNT:  bus_rdata <= DATA_W'(cnt_q);
        RS_CUR:  bus_rdata <= low_found ? DATA_W'(low_idx) : '1;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R5
  cur_none_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2) && (lvl_q & en_q) == '0)
    |=> bus_rdata == '1);

  // R11
  bad_access_err_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr[ADDR_W-1:2] > (ADDR_W-2)'(2)) |=> (bus_err && bus_rdata == '0));

  // R10
  bad_index_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_wdata >= DATA_W'(NUM_SRC) &&
     (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4) || bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(5)))
    |=> ($stable(en_q) && !bus_err));
endmodule

// File: tb/tb_cnt_irq_ctrl.sv
`timescale 1ns/1ps
module tb_cnt_irq_ctrl;
  localparam int          N   = 64;
  localparam logic [31:0] ID  = 32'h1C7A_0040;
  localparam logic [63:0] B0  = 64'h1;
  localparam logic [63:0] B3  = 64'h8;
  localparam logic [63:0] B10 = 64'h400;
  localparam logic [63:0] B63 = 64'h8000_0000_0000_0000;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  typedef struct packed {
    logic [1:0]  kind;   // 0 idle, 1 write, 2 read
    logic [9:0]  widx;
    logic [1:0]  lo;
    logic [31:0] wdata;
    logic [63:0] irq;
    logic        e_irq;
    logic [31:0] e_rd;
    logic        e_err;
  } vec_t;

  localparam int NV = 31;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 10'd5, 2'd0, 32'd3,   64'h0,     1'b0, 32'd0, 1'b0},
    '{2'd0, 10'd0, 2'd0, 32'd0,   B3,        1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd0, 32'd0,   B3,        1'b1, 32'd1, 1'b0},
    '{2'd2, 10'd2, 2'd0, 32'd0,   B3,        1'b1, 32'd3, 1'b0},
    '{2'd0, 10'd0, 2'd0, 32'd0,   B3|B10,    1'b1, 32'd0, 1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd10,  B3|B10,    1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd0, 32'd0,   B3|B10,    1'b1, 32'd2, 1'b0},
    '{2'd2, 10'd2, 2'd0, 32'd0,   B3|B10,    1'b1, 32'd3, 1'b0},
    '{2'd0, 10'd0, 2'd0, 32'd0,   B10,       1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd2, 2'd0, 32'd0,   B10,       1'b1, 32'd10, 1'b0},
    '{2'd1, 10'd4, 2'd0, 32'd10,  B10,       1'b0, 32'd0, 1'b0},
    '{2'd2, 10'd2, 2'd0, 32'd0,   B10,       1'b0, ONES,  1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd64,  B10,       1'b0, 32'd0, 1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd63,  B10|B63,   1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd0, 32'd0,   B10|B63,   1'b1, 32'd1, 1'b0},
    '{2'd1, 10'd4, 2'd0, 32'd63,  B10,       1'b0, 32'd0, 1'b0},
    '{2'd2, 10'd0, 2'd1, 32'd0,   B10,       1'b0, ID,    1'b0},
    '{2'd2, 10'd7, 2'd0, 32'd0,   B10,       1'b0, 32'd0, 1'b1},
    '{2'd1, 10'd1, 2'd0, 32'd5,   B10,       1'b0, 32'd0, 1'b1},
    '{2'd1, 10'd5, 2'd0, 32'd0,   B0|B10,    1'b1, 32'd0, 1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd10,  B0|B10,    1'b1, 32'd0, 1'b0},
    '{2'd1, 10'd3, 2'd0, 32'd0,   B0|B10,    1'b0, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd0, 32'd0,   B0|B10,    1'b0, 32'd0, 1'b0},
    '{2'd2, 10'd2, 2'd0, 32'd0,   B0|B10,    1'b0, ONES,  1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd0,   B0|B10,    1'b1, 32'd0, 1'b0},
    '{2'd1, 10'd5, 2'd0, 32'd0,   B0|B10,    1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd3, 32'd0,   B0|B10,    1'b1, 32'd1, 1'b0},
    '{2'd1, 10'd4, 2'd0, 32'd200, B0|B10,    1'b1, 32'd0, 1'b0},
    '{2'd2, 10'd1, 2'd2, 32'd0,   B0|B10,    1'b1, 32'd1, 1'b0},
    '{2'd1, 10'd6, 2'd0, 32'd0,   B0|B10,    1'b1, 32'd0, 1'b1},
    '{2'd2, 10'd4, 2'd0, 32'd0,   B0|B10,    1'b1, 32'd0, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq_in = '0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_rdata;
  logic          bus_err;
  logic          irq_out;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cnt_irq_ctrl #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_out(irq_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one access, wait for the edge, sample 2 ns after it
  task automatic step(input logic [1:0] kind, input logic [9:0] widx, input logic [1:0] lo,
                      input logic [31:0] wdata, input logic [N-1:0] irq);
    irq_in    = irq;
    bus_addr  = {widx, lo};
    bus_wdata = wdata;
    bus_wr    = (kind == 2'd1);
    bus_rd    = (kind == 2'd2);
    @(posedge clk);
    #2;
    bus_wr = 1'b0;
    bus_rd = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    chk("R1 reset irq_out", 32'(irq_out), 32'd0);
    chk("R11 reset bus_err", 32'(bus_err), 32'd0);
    chk("R3 reset rdata", bus_rdata, 32'd0);
    rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10 R11 R12
    for (int v = 0; v < NV; v++) begin
      step(VEC[v].kind, VEC[v].widx, VEC[v].lo, VEC[v].wdata, VEC[v].irq);
      chk($sformatf("R1 vec%0d irq_out", v), 32'(irq_out), 32'(VEC[v].e_irq));
      chk($sformatf("R11 vec%0d bus_err", v), 32'(bus_err), 32'(VEC[v].e_err));
      if (VEC[v].kind == 2'd2)
        chk($sformatf("R4/R5 vec%0d rdata", v), bus_rdata, VEC[v].e_rd);
    end

    // R7 reset mid-run clears enables; lines stay high
    rst = 1'b1;
    step(2'd0, 10'd0, 2'd0, 32'd0, B0 | B10);
    step(2'd0, 10'd0, 2'd0, 32'd0, B0 | B10);
    rst = 1'b0;
    step(2'd0, 10'd0, 2'd0, 32'd0, B0 | B10);
    chk("R1 after reset irq_out", 32'(irq_out), 32'd0);
    step(2'd2, 10'd1, 2'd0, 32'd0, B0 | B10);
    chk("R4 after reset count", bus_rdata, 32'd0);

    // R6 many lines move in one cycle
    step(2'd0, 10'd0, 2'd0, 32'd0, '0);
    step(2'd1, 10'd5, 2'd0, 32'd0, '0);
    step(2'd1, 10'd5, 2'd0, 32'd10, '0);
    step(2'd1, 10'd5, 2'd0, 32'd63, '0);
    chk("R6 enables without level", 32'(irq_out), 32'd0);
    step(2'd0, 10'd0, 2'd0, 32'd0, '1);
    chk("R6 burst rise irq_out", 32'(irq_out), 32'd1);
    step(2'd2, 10'd1, 2'd0, 32'd0, '1);
    chk("R6 burst rise count", bus_rdata, 32'd3);
    step(2'd2, 10'd2, 2'd0, 32'd0, '1);
    chk("R5 lowest of burst", bus_rdata, 32'd0);
    step(2'd1, 10'd4, 2'd0, 32'd0, '1);
    step(2'd2, 10'd2, 2'd0, 32'd0, '1);
    chk("R9 lowest after disable", bus_rdata, 32'd10);
    step(2'd0, 10'd0, 2'd0, 32'd0, '0);
    chk("R6 burst fall irq_out", 32'(irq_out), 32'd0);
    step(2'd2, 10'd1, 2'd0, 32'd0, '0);
    chk("R6 burst fall count", bus_rdata, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule